// File: doc/BRIEF.md
# Boot-Time Memory Relocation and Option Registers

This block holds two small system registers that software sets up right after reset. The mapping register has two nibbles. Its upper nibble picks the 4-Kbyte page whose first 256 bytes hold the on-chip RAM. Its lower nibble picks the 4-Kbyte page whose first 64 bytes hold the control-register block. The option register holds seven configuration bits that drive other logic. Three of them can be changed at any time. Four of them are protected, and one position is hard-wired to zero.

The protected contents are guarded by a time window. In normal mode, software gets one protected write, and only during the first 64 E-clock cycles after reset. The window closes at that first write to either register, or when the cycle counter expires, whichever comes first. After that, the protected contents hold until the next reset. In special mode the protected contents stay writable at all times. The block also decodes every bus address into a RAM select and a register-block select, and these selects follow the current mapping value.

Top module: `bootmap_regs`

## Requirements
- R1: After reset, the mapping register reads $01 (RAM on page 0, register block on page 1) and the option register reads $10.
- R2: `regSel` is high exactly for addresses $n000..$n03F, where n is mapping bits 3..0. In that block, offset $3D reads the mapping register and offset $39 reads the option register. Reads of any other offset return 0.
- R3: `ramSel` is high for addresses $m000..$m0FF, where m is mapping bits 7..4, and low outside that range.
- R4: When both selects would match one address, `regSel` wins and `ramSel` is low. The rest of the RAM range keeps `ramSel`.
- R5: In normal mode, the first mapping-register write inside the window is accepted. Every later write to the mapping register is ignored until reset.
- R6: The window covers E-cycle indices 0..63 after reset release, counting only cycles with `eClkEn` high. A protected write at index 63 is accepted. One at index 64 or later is ignored.
- R7: Option bits 7, 6 and 4 take the written value on every write, in any mode. Option bit 2 always reads 0.
- R8: Option bits 5, 3, 1 and 0 are protected in the same way as the mapping register. A write to either register closes the window for both.
- R9: In special mode (`specialMode` high), the mapping register and the protected option bits accept any number of writes at any time.
- R10: A write takes effect only on a clock edge where both `wrEn` and `eClkEn` are high.
- R11: After a relocation, both registers are reached at the new block base plus their offsets, and no longer at the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eClkEn | input | 1 | Bus-cycle (E-clock) enable. Counts the window and qualifies writes. |
| specialMode | input | 1 | High in special modes: protected bits stay writable |
| addr | input | 16 | Bus address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data. Zero when there is no register read. |
| ramSel | output | 1 | Address hits the RAM range |
| regSel | output | 1 | Address hits the 64-byte register block |
| mapVal | output | 8 | Current mapping register value |
| optVal | output | 8 | Current option register value |

## Verification
Three cases can fall in the same cycle: a protected write, the expiry of the window, and a write made to a register that has just been relocated. In the expiry case, the bench counts E-cycles itself and places a mapping write on index 63 in one run and on index 64 in another. It expects the first to be accepted and the second to leave $01 in place. It also checks that a first write to the option register closes the window for the mapping register in the same edge. After each relocation, the bench reads the registers through the new base address, so a decode that still used the old base would return wrong data.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
  // Strobes from the control unit to the register datapath
  typedef struct packed {
    logic mapWr;   // write to the mapping register this edge
    logic optWr;   // write to the option register this edge
    logic protOk;  // protected contents may be written this edge
  } ctlStrobe_t;
endpackage

// File: rtl/bootmap_ctrl.sv
module bootmap_ctrl
  import bootmap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BITS  = 12,
  parameter int RAM_BYTES  = 256,
  parameter int REG_BYTES  = 64,
  parameter int WIN_CYCLES = 64,
  parameter int MAP_OFS    = 'h3D,
  parameter int OPT_OFS    = 'h39,
  localparam int NIB_W  = ADDR_W - PAGE_BITS,
  localparam int REG_AW = $clog2(REG_BYTES),
  localparam int RAM_AW = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eClkEn,
  input  logic              specialMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [NIB_W-1:0]  ramNib,
  input  logic [NIB_W-1:0]  regNib,
  output logic              ramSel,
  output logic              regSel,
  output logic [REG_AW-1:0] regOfs,
  output ctlStrobe_t        strb
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);

  logic [CNT_W-1:0] winCnt;
  logic             locked;
  logic             windowOpen;
  logic             ramHit;
  logic             busWr;
  logic [NIB_W-1:0] pageNib;

  assign pageNib = addr[ADDR_W-1:PAGE_BITS];
  assign regOfs  = addr[REG_AW-1:0];

  // Address decode. The register block has priority over RAM.
  always_comb begin
    regSel = (pageNib == regNib) && (addr[PAGE_BITS-1:REG_AW] == '0);
    ramHit = (pageNib == ramNib) && (addr[PAGE_BITS-1:RAM_AW] == '0);
    ramSel = ramHit && !regSel;
  end

  assign windowOpen = !locked && (winCnt < CNT_W'(WIN_CYCLES));
  assign busWr      = wrEn && eClkEn && regSel;

  always_comb begin
    strb.mapWr  = busWr && (regOfs == REG_AW'(MAP_OFS));
    strb.optWr  = busWr && (regOfs == REG_AW'(OPT_OFS));
    strb.protOk = specialMode || windowOpen;
  end

  // E-cycle counter. It saturates at the window length and restarts only on reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (eClkEn && (winCnt < CNT_W'(WIN_CYCLES))) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  // Lock flag. The first protected write in normal mode closes the window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b0;
    end else if (!specialMode && (strb.mapWr || strb.optWr)) begin
      locked <= 1'b1;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= CNT_W'(WIN_CYCLES));

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  // R8: an accepted protected write in normal mode shuts the window for both registers
  assert_window_close_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!specialMode && (strb.mapWr || strb.optWr) && strb.protOk)
      |=> (specialMode || !strb.protOk));
endmodule

// File: rtl/bootmap_dp.sv
module bootmap_dp
  import bootmap_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int REG_AW     = 6,
  parameter int MAP_OFS    = 'h3D,
  parameter int OPT_OFS    = 'h39,
  parameter logic [DATA_W-1:0] MAP_RESET = 8'h01,
  parameter logic [DATA_W-1:0] OPT_RESET = 8'h10,
  parameter logic [DATA_W-1:0] PROT_MASK = 8'h2B,
  parameter logic [DATA_W-1:0] FREE_MASK = 8'hD0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              regSel,
  input  logic [REG_AW-1:0] regOfs,
  output logic [DATA_W-1:0] mapQ,
  output logic [DATA_W-1:0] optQ,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] optNext;

  // Per-bit option update: free bits always, protected bits only when allowed
  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      if (FREE_MASK[b])                    optNext[b] = wrData[b];
      else if (PROT_MASK[b] && strb.protOk) optNext[b] = wrData[b];
      else if (PROT_MASK[b])               optNext[b] = optQ[b];
      else                                 optNext[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapQ <= MAP_RESET;
    end else if (strb.mapWr && strb.protOk) begin
      mapQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      optQ <= OPT_RESET;
    end else if (strb.optWr) begin
      optQ <= optNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn && regSel) begin
      if (regOfs == REG_AW'(MAP_OFS))      rdData = mapQ;
      else if (regOfs == REG_AW'(OPT_OFS)) rdData = optQ;
    end
  end

  assert_map_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.protOk |=> $stable(mapQ));

  assert_opt_prot_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.protOk |=> $stable(optQ & PROT_MASK));
endmodule

// File: rtl/bootmap_regs.sv
module bootmap_regs
  import bootmap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BITS  = 12,
  parameter int RAM_BYTES  = 256,
  parameter int REG_BYTES  = 64,
  parameter int WIN_CYCLES = 64,
  parameter int MAP_OFS    = 'h3D,
  parameter int OPT_OFS    = 'h39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eClkEn,
  input  logic              specialMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              ramSel,
  output logic              regSel,
  output logic [DATA_W-1:0] mapVal,
  output logic [DATA_W-1:0] optVal
);
  localparam int NIB_W  = DATA_W / 2;
  localparam int REG_AW = $clog2(REG_BYTES);

  ctlStrobe_t        strb;
  logic [REG_AW-1:0] regOfs;

  bootmap_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .RAM_BYTES(RAM_BYTES),
    .REG_BYTES(REG_BYTES), .WIN_CYCLES(WIN_CYCLES),
    .MAP_OFS(MAP_OFS), .OPT_OFS(OPT_OFS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .eClkEn(eClkEn), .specialMode(specialMode),
    .addr(addr), .wrEn(wrEn),
    .ramNib(mapVal[DATA_W-1:NIB_W]), .regNib(mapVal[NIB_W-1:0]),
    .ramSel(ramSel), .regSel(regSel), .regOfs(regOfs), .strb(strb)
  );

  bootmap_dp #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .MAP_OFS(MAP_OFS), .OPT_OFS(OPT_OFS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdEn(rdEn),
    .regSel(regSel), .regOfs(regOfs),
    .mapQ(mapVal), .optQ(optVal), .rdData(rdData)
  );
endmodule

// File: tb/bootmap_regs_tb.sv
module bootmap_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eClkEn = 1'b1;
  logic        specialMode = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic        ramSel, regSel;
  logic [7:0]  mapVal, optVal;

  int checkCnt = 0;
  int failCnt  = 0;
  int eCount   = 0;
  int cycCnt   = 0;

  always #5 clk = ~clk;

  bootmap_regs dut_i (
    .clk(clk), .rstN(rstN), .eClkEn(eClkEn), .specialMode(specialMode),
    .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
    .ramSel(ramSel), .regSel(regSel), .mapVal(mapVal), .optVal(optVal)
  );

  // Bench-side count of E-cycles since reset release
  always @(posedge clk) begin
    if (!rstN) eCount <= 0;
    else if (eClkEn) eCount <= eCount + 1;
  end

  always @(posedge clk) begin
    cycCnt <= cycCnt + 1;
    if (cycCnt == 150000) begin
      failCnt = failCnt + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [15:0] a, input logic [7:0] exp);
    addr = a; rdEn = 1'b1;
    #1;
    check(req, rdData, exp);
    rdEn = 1'b0;
  endtask

  task automatic selCheck(input string req, input logic [15:0] a, input logic expRam, input logic expReg);
    addr = a;
    #1;
    check(req, {ramSel, regSel}, {expRam, expReg});
  endtask

  task automatic testReset();
    specialMode = 1'b0; eClkEn = 1'b1;
    doReset();
    readCheck("R1 map reset", 16'h103D, 8'h01);
    readCheck("R1 opt reset", 16'h1039, 8'h10);
    readCheck("R2 other offset", 16'h1000, 8'h00);
    selCheck("R2 block start", 16'h1000, 1'b0, 1'b1);
    selCheck("R2 block end", 16'h103F, 1'b0, 1'b1);
    selCheck("R2 past block", 16'h1040, 1'b0, 1'b0);
    selCheck("R3 ram start", 16'h0000, 1'b1, 1'b0);
    selCheck("R3 ram end", 16'h00FF, 1'b1, 1'b0);
    selCheck("R3 past ram", 16'h0100, 1'b0, 1'b0);
  endtask

  task automatic testMapOnce();
    doReset();
    busWrite(16'h103D, 8'h23);
    readCheck("R11 map at new base", 16'h303D, 8'h23);
    readCheck("R11 old base empty", 16'h103D, 8'h00);
    selCheck("R3 relocated ram", 16'h2010, 1'b1, 1'b0);
    busWrite(16'h303D, 8'h45);
    readCheck("R5 second map write ignored", 16'h303D, 8'h23);
    busWrite(16'h3039, 8'hFF);
    readCheck("R7 free bits after lock", 16'h3039, 8'hD0);
  endtask

  task automatic testOptFirst();
    doReset();
    busWrite(16'h1039, 8'h2B);
    readCheck("R8 protected opt write", 16'h1039, 8'h2B);
    busWrite(16'h103D, 8'h02);
    readCheck("R8 shared lock blocks map", 16'h103D, 8'h01);
    busWrite(16'h1039, 8'h04);
    readCheck("R7 bit2 zero, prot held", 16'h1039, 8'h2B);
  endtask

  task automatic testWindow();
    doReset();
    while (eCount != 64) @(negedge clk);
    busWrite(16'h103D, 8'h55);
    readCheck("R6 write at index 64 ignored", 16'h103D, 8'h01);
    doReset();
    while (eCount != 63) @(negedge clk);
    busWrite(16'h103D, 8'h55);
    readCheck("R6 write at index 63 taken", 16'h503D, 8'h55);
  endtask

  task automatic testEclk();
    eClkEn = 1'b0;
    doReset();
    repeat (100) @(negedge clk);
    busWrite(16'h103D, 8'h61);
    readCheck("R10 write without eClkEn ignored", 16'h103D, 8'h01);
    eClkEn = 1'b1;
    busWrite(16'h103D, 8'h61);
    readCheck("R10 window not advanced while eClkEn low", 16'h103D, 8'h61);
    selCheck("R3 ram page 6", 16'h6080, 1'b1, 1'b0);
  endtask

  task automatic testSpecial();
    specialMode = 1'b1;
    doReset();
    while (eCount < 100) @(negedge clk);
    busWrite(16'h103D, 8'h7A);
    readCheck("R9 late map write", 16'hA03D, 8'h7A);
    busWrite(16'hA03D, 8'hC3);
    readCheck("R9 repeated map write", 16'h303D, 8'hC3);
    busWrite(16'h3039, 8'hFF);
    readCheck("R9 opt all bits", 16'h3039, 8'hFB);
    busWrite(16'h3039, 8'h00);
    readCheck("R9 opt cleared", 16'h3039, 8'h00);
    specialMode = 1'b0;
  endtask

  task automatic testOverlap();
    doReset();
    busWrite(16'h103D, 8'h11);
    selCheck("R4 overlap reg wins", 16'h1020, 1'b0, 1'b1);
    selCheck("R4 ram above block", 16'h1050, 1'b1, 1'b0);
    selCheck("R4 ram end", 16'h10FF, 1'b1, 1'b0);
    readCheck("R4 register still readable", 16'h103D, 8'h11);
  endtask

  initial begin
    testReset();
    testMapOnce();
    testOptFirst();
    testWindow();
    testEclk();
    testSpecial();
    testOverlap();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule